// File: doc/BRIEF.md
# Smart Card Bit-Rate and Card Clock Generator

This block derives every timing reference a smart card serial port needs from the internal system clock alone. An 8-bit divisor `N` and a 2-bit prescaler select `n` set the bit period to 744·4^n·(N+1) system clocks. Within each bit period the card clock on the SCK output completes exactly 372 cycles. The block also delivers a one-cycle bit-boundary pulse and a one-cycle pulse at 16 times the bit rate, which the receive sampler uses.

Software writes new values onto the `div_n_i` and `sel_i` inputs and then pulses `reload_i`. The reload captures the values and restarts the prescaler, the divisor counter, the SCK phase and the bit sequencer together, so the first bit period after a change has its full length. Values on the setting inputs have no effect until a reload. When `cke_i` is low the SCK pin stays low, and the tick outputs keep running from the internal phase.

Top module: `scard_baud_gen`

## Requirements
- R1: While `rst_n` is low, `bit_tick_o`, `ovs_tick_o` and `sck_o` are 0 after the first clock edge. On leaving reset the block runs with N=0 and n=0 until the first reload.
- R2: A change on `div_n_i` or `sel_i` without a reload leaves the timing of all three outputs unchanged.
- R3: A clock edge with `reload_i` high captures `div_n_i` and `sel_i`, restarts all counting, and drives all three outputs to 0 in the following cycle. No tick is emitted at that edge, even if one was due. Edge k after the reload edge is the k-th counted edge.
- R4: Let H = 4^n·(N+1), with `sel_i` coding n directly (00→0, 01→1, 10→2, 11→3). The internal SCK phase starts low and toggles at every counted edge k that is a multiple of H.
- R5: `bit_tick_o` is high for exactly the one cycle after counted edge k = 744·H·m (m ≥ 1), that is, once every 372 SCK periods.
- R6: Let j = k/H be the count of finished SCK half-periods. `ovs_tick_o` is high for one cycle after each half-period end at which floor(16·j/744) increases. This gives 16 pulses per bit period, and the 16th coincides with `bit_tick_o`.
- R7: With `cke_i` low, `sck_o` is 0. With `cke_i` high, `sck_o` follows the internal phase. The ticks do not depend on `cke_i`.
- R8: In every cycle in which `bit_tick_o` is high, `sck_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_n_i | input | 8 | Divisor N, taken on reload |
| sel_i | input | 2 | Prescaler select n, taken on reload |
| reload_i | input | 1 | Capture settings and restart counting |
| cke_i | input | 1 | Drive SCK when high, hold it low when low |
| bit_tick_o | output | 1 | One-cycle pulse at each bit boundary |
| ovs_tick_o | output | 1 | One-cycle pulse at 16x the bit rate |
| sck_o | output | 1 | Card clock, 372 periods per bit |

## Verification
The last oversample pulse of a bit and the bit-boundary pulse fall on the same edge. A reload can also arrive on the very edge at which both are due. The bench steers a reload onto the cycle just before a predicted bit boundary and onto a cycle in which the bit pulse is showing. It then judges from the model that neither tick appears at the reload edge and that a full bit period follows. Every cycle is compared against a behavioural model that counts edges since the last reload and applies the period formulas directly.

// File: rtl/scard_baud_pkg.sv
package scard_baud_pkg;
   // Number of prescaler counter bits needed to reach 4^n - 1 for the largest n
   function automatic int pre_width(input int sel_w);
      return 2 * ((1 << sel_w) - 1);
   endfunction

   // Bit count for a counter that must hold values 0 .. limit
   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

   typedef struct packed {
      logic half_end;
      logic bit_end;
      logic ovs_end;
   } scard_evt_t;
endpackage

// File: rtl/scard_prescaler.sv
module scard_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             pre_tick
);
   import scard_baud_pkg::*;

   localparam int PRE_W = pre_width(SEL_W);

   logic [PRE_W:0]   span;
   logic [PRE_W-1:0] lim;
   logic [PRE_W-1:0] cnt;

   // 4^sel as a one-hot value, minus one, gives the terminal count
   assign span     = (PRE_W+1)'(1) << {sel, 1'b0};
   assign lim      = PRE_W'(span - (PRE_W+1)'(1));
   assign pre_tick = (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
      end else if (pre_tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + PRE_W'(1);
      end
   end
endmodule

// File: rtl/scard_divider.sv
module scard_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             pre_tick,
   input  logic [DIV_W-1:0] div_n,
   output logic             half_end
);
   logic [DIV_W-1:0] cnt;

   assign half_end = pre_tick && (cnt == div_n);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
      end else if (half_end) begin
         cnt <= '0;
      end else if (pre_tick) begin
         cnt <= cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/scard_bit_seq.sv
module scard_bit_seq #(
   parameter int SCK_PER_BIT = 372,
   parameter int OVS         = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic half_end,
   output logic sck_q,
   output logic bit_tick,
   output logic ovs_tick
);
   import scard_baud_pkg::*;

   localparam int HALVES = 2 * SCK_PER_BIT;
   localparam int HW     = cnt_width(HALVES - 1);

   logic [HW-1:0] hcnt;
   logic          last_half;

   assign last_half = (hcnt == HW'(HALVES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         hcnt     <= '0;
         sck_q    <= 1'b0;
         bit_tick <= 1'b0;
      end else begin
         bit_tick <= half_end && last_half;
         if (half_end) begin
            sck_q <= ~sck_q;
            hcnt  <= last_half ? '0 : hcnt + HW'(1);
         end
      end
   end

   generate
      if (HALVES % OVS == 0) begin : g_even
         localparam int STEP = HALVES / OVS;
         localparam int SW   = cnt_width(STEP - 1);
         logic [SW-1:0] scnt;
         logic          wrap;
         assign wrap = (scnt == SW'(STEP - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               scnt     <= '0;
               ovs_tick <= 1'b0;
            end else begin
               ovs_tick <= half_end && wrap;
               if (half_end) begin
                  scnt <= wrap ? '0 : scnt + SW'(1);
               end
            end
         end
      end else begin : g_frac
         localparam int AW = cnt_width(HALVES + OVS);
         logic [AW-1:0] acc;
         logic [AW-1:0] sum;
         logic          over;
         assign sum  = acc + AW'(OVS);
         assign over = (sum >= AW'(HALVES));
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               acc      <= '0;
               ovs_tick <= 1'b0;
            end else begin
               ovs_tick <= half_end && over;
               if (half_end) begin
                  acc <= over ? sum - AW'(HALVES) : sum;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/scard_baud_gen.sv
module scard_baud_gen #(
   parameter int DIV_W       = 8,
   parameter int SEL_W       = 2,
   parameter int SCK_PER_BIT = 372,
   parameter int OVS         = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_n_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             reload_i,
   input  logic             cke_i,
   output logic             bit_tick_o,
   output logic             ovs_tick_o,
   output logic             sck_o
);
   import scard_baud_pkg::*;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("SEL_W must be 1 to 3");
      end
      if (OVS < 1 || OVS > 2 * SCK_PER_BIT) begin : g_bad_ovs
         $error("OVS must lie between 1 and twice SCK_PER_BIT");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [SEL_W-1:0] sel_q;
   scard_evt_t       evt;
   logic             pre_tick;
   logic             sck_q;

   // Settings only take effect when a reload restarts the chain
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         sel_q <= '0;
      end else if (reload_i) begin
         div_q <= div_n_i;
         sel_q <= sel_i;
      end
   end

   scard_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (reload_i),
      .sel      (sel_q),
      .pre_tick (pre_tick)
   );

   scard_divider #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (reload_i),
      .pre_tick (pre_tick),
      .div_n    (div_q),
      .half_end (evt.half_end)
   );

   scard_bit_seq #(.SCK_PER_BIT(SCK_PER_BIT), .OVS(OVS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (reload_i),
      .half_end (evt.half_end),
      .sck_q    (sck_q),
      .bit_tick (evt.bit_end),
      .ovs_tick (evt.ovs_end)
   );

   assign bit_tick_o = evt.bit_end;
   assign ovs_tick_o = evt.ovs_end;
   assign sck_o      = sck_q & cke_i;
endmodule

// File: rtl/scard_baud_gen_chk.sv
module scard_baud_gen_chk #(
   parameter int OVS = 16
) (
   input logic clk,
   input logic rst_n,
   input logic reload_i,
   input logic bit_tick_o,
   input logic ovs_tick_o,
   input logic sck_o
);
   localparam int CW = $clog2(OVS + 1) + 1;

   logic [CW-1:0] ovs_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovs_seen <= '0;
      end else if (bit_tick_o || reload_i) begin
         ovs_seen <= '0;
      end else if (ovs_tick_o) begin
         ovs_seen <= ovs_seen + CW'(1);
      end
   end

   // R3: outputs quiet right after a reload edge
   a_r3_quiet_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (!bit_tick_o && !ovs_tick_o && !sck_o));

   // R5: bit pulse lasts one cycle
   a_r5_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick_o |=> !bit_tick_o);

   // R6: last oversample pulse lands on the bit boundary
   a_r6_ovs_at_bit: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick_o |-> ovs_tick_o);

   // R6: oversample pulse lasts one cycle
   a_r6_ovs_single: assert property (@(posedge clk) disable iff (!rst_n)
      ovs_tick_o |=> !ovs_tick_o);

   // R6: OVS-1 oversample pulses precede each bit pulse
   a_r6_ovs_count: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick_o |-> (ovs_seen == CW'(OVS - 1)));

   // R8: SCK is low at every bit boundary
   a_r8_sck_low_at_bit: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick_o |-> !sck_o);
endmodule

bind scard_baud_gen scard_baud_gen_chk #(.OVS(OVS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reload_i   (reload_i),
   .bit_tick_o (bit_tick_o),
   .ovs_tick_o (ovs_tick_o),
   .sck_o      (sck_o)
);

// File: tb/scard_baud_gen_bench.sv
module scard_baud_gen_bench;
   localparam int HALVES = 744;
   localparam int NOVS   = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] div_n;
   logic [1:0] sel;
   logic       reload;
   logic       cke;
   logic       bit_tick, ovs_tick, sck;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    armed = 0;
   bit    done  = 0;
   string phase = "R1";

   // behavioural model state
   int m_n, m_sel, k, h, j;
   bit m_sck, e_bit, e_ovs;

   always #4 clk = ~clk;

   scard_baud_gen u_scard_baud_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_n_i    (div_n),
      .sel_i      (sel),
      .reload_i   (reload),
      .cke_i      (cke),
      .bit_tick_o (bit_tick),
      .ovs_tick_o (ovs_tick),
      .sck_o      (sck)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s/%s %s: actual=%0d expected=%0d", phase, tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      armed = 1;
      if (!rst_n) begin
         m_n = 0; m_sel = 0; k = 0; m_sck = 0; e_bit = 0; e_ovs = 0;
      end else if (reload) begin
         m_n = div_n; m_sel = sel; k = 0; m_sck = 0; e_bit = 0; e_ovs = 0;
      end else begin
         k++;
         h = (m_n + 1) * (1 << (2 * m_sel));
         if (k % h == 0) begin
            j = k / h;
            m_sck = ~m_sck;
            e_bit = (j % HALVES == 0);
            e_ovs = ((NOVS * j) / HALVES) != ((NOVS * (j - 1)) / HALVES);
         end else begin
            e_bit = 0;
            e_ovs = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (armed && !done) begin
         check(bit_tick == e_bit, "R5", "bit_tick_o", bit_tick, e_bit);
         check(ovs_tick == e_ovs, "R6", "ovs_tick_o", ovs_tick, e_ovs);
         check(sck == (m_sck & cke), "R4_R7", "sck_o", sck, m_sck & cke);
         if (bit_tick) check(sck == 1'b0, "R8", "sck_o at bit tick", sck, 0);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reload(input int nv, input int sv);
      div_n = 8'(nv); sel = 2'(sv); reload = 1'b1;
      step(1);
      reload = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; reload = 1'b0; cke = 1'b1; div_n = '0; sel = '0;
      step(4);
      // R1: reset state
      @(negedge clk);
      check(bit_tick == 0 && ovs_tick == 0 && sck == 0, "R1", "outputs in reset",
            {bit_tick, ovs_tick, sck}, 0);
      step(1);
      rst_n = 1'b1;
      phase = "R1";
      step(1600);

      // R2: settings change without reload has no effect
      phase = "R2";
      div_n = 8'd2; sel = 2'b01;
      step(800);

      // R3: reload takes the new values, first period full length
      phase = "R3";
      reload = 1'b1;
      step(1);
      reload = 1'b0;
      @(negedge clk);
      check(bit_tick == 0 && ovs_tick == 0 && sck == 0, "R3", "outputs after reload",
            {bit_tick, ovs_tick, sck}, 0);
      step(18000);

      // R7: clock enable gates only the pin
      phase = "R7";
      do_reload(1, 0);
      step(500);
      cke = 1'b0;
      step(3000);
      cke = 1'b1;
      step(2000);

      // R4: extreme divisor and highest prescaler code
      phase = "R4";
      do_reload(255, 0);
      step(1200);
      do_reload(0, 3);
      step(2000);
      do_reload(3, 2);
      step(600);

      // R3/R6: reload coinciding with a visible bit tick
      phase = "R3";
      do_reload(0, 0);
      do step(1); while (!e_bit);
      do_reload(0, 0);
      step(800);
      // reload on the edge where bit and last oversample tick are due
      do step(1); while (!(k % HALVES == HALVES - 1));
      do_reload(0, 0);
      @(negedge clk);
      check(bit_tick == 0 && ovs_tick == 0, "R3", "ticks suppressed by reload",
            {bit_tick, ovs_tick}, 0);
      phase = "R6";
      step(1600);

      finish_run();
   end
endmodule